// File: doc/BRIEF.md
# Byte/Word Flash Bus Interface

This block is the host-facing bus front end of a parallel NOR-style flash memory model. The host side has three active-low strobes: chip enable, write enable and output enable. It also has a width select, an address bus and a bidirectional 16-bit data bus. The block does not contain the memory array, the command decoding or the program/erase sequencing. It only turns the bus protocol into clean internal transactions.

On a write, an asynchronous latch captures the address and another captures the data. Each latch is clocked by the combined write strobe, which is the OR of chip enable and write enable. The address is taken when the strobe falls, that is, when the later of the two enables goes low. The data is taken when the strobe rises, that is, when the first of the two enables goes high. A synchroniser then moves the end of the write into the internal clock domain. It emits a one-cycle pulse toward the command interpreter, and the pulse carries the latched address and data.

On a read, a source select from the command interpreter is registered when the read cycle opens. That source can be the array, the identification code, the protection code or the status flags. The selected data is then driven onto the bus while chip enable and output enable are both low. In byte mode only the low lane carries data. The middle pins float, and the top pin becomes the least significant address bit, which picks the half of the array word that is returned.

Top module: `flash_bus_front`

## Requirements
- R1: The write address is captured on the falling edge of the combined write strobe (chip enable OR write enable), so the address present when the later of the two enables falls is the one kept; address changes before or after that edge have no effect.
- R2: The write data is captured on the rising edge of the combined write strobe, so the data present when the first of the two enables rises is kept; later data changes have no effect.
- R3: With word_mode high, all 16 data pins carry write data and read data, and the write address is the bus address zero-extended by one bit.
- R4: With word_mode low, only dq[7:0] carry data and dq[14:8] are never driven by the block. dq[15] is an input supplying the least significant address bit, so the write address is {addr, dq[15]}. The upper byte of the write data is forced to zero whatever the upper pins carry.
- R5: In byte mode an array read returns the lower byte of the array word when dq[15] is 0, and the upper byte when dq[15] is 1, on dq[7:0].
- R6: The block drives the data bus only while ce_n and oe_n are both low and rst_n is high; otherwise every pin is high-impedance.
- R7: Read source encodings are 0 array, 1 identification code, 2 protection code and 3 status. The three non-array sources occupy the low byte, and in word mode the upper byte reads zero.
- R8: The status byte places data polling at bit 7, the first toggle bit at bit 6, the error flag at bit 5, the erase timer at bit 3 and the second toggle bit at bit 2, with bits 4, 1 and 0 zero. stat_flags is ordered {poll, toggle6, error, timer, toggle2} from bit 4 down to bit 0.
- R9: The read source is registered on the falling edge of ce_n OR oe_n; a change of rd_src during an open read cycle does not alter the driven data until the next read cycle.
- R10: Every write cycle yields exactly one wr_pulse, one clock wide, and wr_addr and wr_data hold the latched values throughout it.
- R11: While rst_n is low, the data bus floats and no wr_pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock for the write-pulse synchroniser |
| rst_n | input | 1 | Active-low reset pin; floats the bus and clears state |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 selects the 16-bit bus, 0 selects the 8-bit bus |
| addr | input | AW | Host address bus |
| dq | inout | DQ_W | Bidirectional data bus; top bit is the low address bit in byte mode |
| rd_src | input | 2 | Read source select from the command interpreter |
| array_data | input | DQ_W | Word read from the array at array_addr |
| id_code | input | 8 | Identification code byte |
| prot_code | input | 8 | Block protection status byte |
| stat_flags | input | 5 | Status flags {poll, toggle6, error, timer, toggle2} |
| array_addr | output | AW+1 | Array read address (word or byte index) |
| wr_pulse | output | 1 | One-cycle write strobe to the command interpreter |
| wr_addr | output | AW+1 | Latched write address |
| wr_data | output | DQ_W | Latched write data |

## Verification
Writes are driven twice in word mode. In the write-enable-controlled pattern the address is moved before and after the write-enable fall. In the chip-enable-controlled pattern the data is moved between the two rising edges. Together they show that the address follows the later falling enable and the data follows the earlier rising one. A byte-mode write drives noise on the upper pins and a 1 on the top pin, which shows the address extension and the zeroed upper byte. Reads go through every source encoding in both widths, with two status flag patterns that set different bits and both settings of the byte-select bit. They also change the source in the middle of a read cycle, and they release each enable and the reset in turn to show exactly when the bus floats.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_PROT   = 2'd2,
        SRC_STATUS = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic poll;
        logic tog_a;
        logic err;
        logic timer;
        logic tog_b;
    } stat_flags_t;

    localparam int STAT_W = 8;

    // Status byte layout: poll 7, toggle 6, error 5, timer 3, toggle 2.
    function automatic logic [STAT_W-1:0] pack_status(stat_flags_t f);
        return {f.poll, f.tog_a, f.err, 1'b0, f.timer, f.tog_b, 2'b00};
    endfunction

endpackage

// File: rtl/fbi_wr_latch.sv
module fbi_wr_latch #(
    parameter int AW   = 8,
    parameter int DQ_W = 16
) (
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            word_mode,
    input  logic [AW-1:0]   addr,
    input  logic [DQ_W-1:0] dq_in,
    output logic            strobe_n,
    output logic [AW:0]     wr_addr,
    output logic [DQ_W-1:0] wr_data
);
    localparam int BYTE_W = DQ_W / 2;

    typedef struct packed {
        logic [AW:0] addr;
    } alat_t;

    typedef struct packed {
        logic [DQ_W-1:0] data;
    } dlat_t;

    alat_t alat_d, alat_q;
    dlat_t dlat_d, dlat_q;

    // Combined strobe: low only while both enables are low.
    assign strobe_n = ce_n | we_n;

    always_comb begin
        alat_d = alat_q;
        if (word_mode) begin
            alat_d.addr = {1'b0, addr};
        end else begin
            alat_d.addr = {addr, dq_in[DQ_W-1]};
        end
    end

    always_comb begin
        dlat_d = dlat_q;
        if (word_mode) begin
            dlat_d.data = dq_in;
        end else begin
            dlat_d.data = {{(DQ_W-BYTE_W){1'b0}}, dq_in[BYTE_W-1:0]};
        end
    end

    // Address taken when the later enable falls.
    always_ff @(negedge strobe_n or negedge rst_n) begin
        if (!rst_n) begin
            alat_q <= '0;
        end else begin
            alat_q <= alat_d;
        end
    end

    // Data taken when the first enable rises.
    always_ff @(posedge strobe_n or negedge rst_n) begin
        if (!rst_n) begin
            dlat_q <= '0;
        end else begin
            dlat_q <= dlat_d;
        end
    end

    assign wr_addr = alat_q.addr;
    assign wr_data = dlat_q.data;

endmodule

// File: rtl/fbi_wr_sync.sv
module fbi_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic pulse
);
    typedef struct packed {
        logic [STAGES:0] chain;
        logic            pulse;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-1:0], strobe_n};
        st_d.pulse = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

    // R10: the strobe toward the command interpreter is one cycle wide.
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

endmodule

// File: rtl/fbi_rd_path.sv
module fbi_rd_path
    import fbi_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            word_mode,
    input  logic            a_m1,
    input  logic [1:0]      rd_src,
    input  logic [DQ_W-1:0] array_data,
    input  logic [7:0]      id_code,
    input  logic [7:0]      prot_code,
    input  logic [4:0]      stat_flags,
    output logic [DQ_W-1:0] out_data,
    output logic            drive_lo,
    output logic            drive_hi
);
    localparam int BYTE_W = DQ_W / 2;

    typedef struct packed {
        rd_src_e src;
    } rsel_t;

    rsel_t rsel_d, rsel_q;
    logic  rd_n;
    logic  drive;
    logic [BYTE_W-1:0] side_byte;

    assign rd_n = ce_n | oe_n;

    always_comb begin
        rsel_d     = rsel_q;
        rsel_d.src = rd_src_e'(rd_src);
    end

    // Source chosen once, when the read cycle opens.
    always_ff @(negedge rd_n or negedge rst_n) begin
        if (!rst_n) begin
            rsel_q.src <= SRC_ARRAY;
        end else begin
            rsel_q <= rsel_d;
        end
    end

    always_comb begin
        case (rsel_q.src)
            SRC_IDENT:  side_byte = BYTE_W'(id_code);
            SRC_PROT:   side_byte = BYTE_W'(prot_code);
            SRC_STATUS: side_byte = BYTE_W'(pack_status(stat_flags_t'(stat_flags)));
            default:    side_byte = '0;
        endcase
    end

    always_comb begin
        out_data = '0;
        if (rsel_q.src == SRC_ARRAY) begin
            if (word_mode) begin
                out_data = array_data;
            end else if (a_m1) begin
                out_data[BYTE_W-1:0] = array_data[DQ_W-1:BYTE_W];
            end else begin
                out_data[BYTE_W-1:0] = array_data[BYTE_W-1:0];
            end
        end else begin
            out_data[BYTE_W-1:0] = side_byte;
        end
    end

    assign drive    = ~rd_n & rst_n;
    assign drive_lo = drive;
    assign drive_hi = drive & word_mode;

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
    parameter int AW          = 8,
    parameter int DQ_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic            word_mode,
    input  logic [AW-1:0]   addr,
    inout  wire  [DQ_W-1:0] dq,
    input  logic [1:0]      rd_src,
    input  logic [DQ_W-1:0] array_data,
    input  logic [7:0]      id_code,
    input  logic [7:0]      prot_code,
    input  logic [4:0]      stat_flags,
    output logic [AW:0]     array_addr,
    output logic            wr_pulse,
    output logic [AW:0]     wr_addr,
    output logic [DQ_W-1:0] wr_data
);
    localparam int BYTE_W = DQ_W / 2;

    logic            strobe_n;
    logic [DQ_W-1:0] out_data;
    logic            drive_lo;
    logic            drive_hi;
    logic            a_m1;

    assign a_m1       = dq[DQ_W-1];
    assign array_addr = word_mode ? {1'b0, addr} : {addr, a_m1};

    fbi_wr_latch #(.AW(AW), .DQ_W(DQ_W)) u_latch (
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .word_mode (word_mode),
        .addr      (addr),
        .dq_in     (dq),
        .strobe_n  (strobe_n),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    fbi_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .pulse    (wr_pulse)
    );

    fbi_rd_path #(.DQ_W(DQ_W)) u_rd (
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .word_mode  (word_mode),
        .a_m1       (a_m1),
        .rd_src     (rd_src),
        .array_data (array_data),
        .id_code    (id_code),
        .prot_code  (prot_code),
        .stat_flags (stat_flags),
        .out_data   (out_data),
        .drive_lo   (drive_lo),
        .drive_hi   (drive_hi)
    );

    for (genvar i = 0; i < DQ_W; i++) begin : g_lane
        if (i < BYTE_W) begin : g_lo
            assign dq[i] = drive_lo ? out_data[i] : 1'bz;
        end else begin : g_hi
            assign dq[i] = drive_hi ? out_data[i] : 1'bz;
        end
    end

    // R6: no lane is driven unless both enables are low.
    a_r6_float: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!drive_lo && !drive_hi));

    // R4: the upper lane stays released in byte mode.
    a_r4_upper_float: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode |-> !drive_hi);

    // R10: the payload is steady while the pulse is presented.
    a_r10_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

// File: tb/flash_bus_front_tb.sv
module flash_bus_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DQ_W       = 16;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            rst_n, ce_n, we_n, oe_n, word_mode;
    logic [AW-1:0]   addr;
    logic [1:0]      rd_src;
    logic [7:0]      id_code, prot_code;
    logic [4:0]      stat_flags;
    logic [DQ_W-1:0] tb_val, tb_en;
    tri   [DQ_W-1:0] dq;
    wire  [AW:0]     array_addr;
    logic [DQ_W-1:0] array_data;
    logic            wr_pulse;
    logic [AW:0]     wr_addr;
    logic [DQ_W-1:0] wr_data;

    int total = 0;
    int fails = 0;
    int pulse_cnt = 0;
    logic [AW:0]     cap_addr;
    logic [DQ_W-1:0] cap_data;
    bit done = 0;

    for (genvar i = 0; i < DQ_W; i++) begin : g_host
        assign dq[i] = tb_en[i] ? tb_val[i] : 1'bz;
    end

    function automatic logic [DQ_W-1:0] arr_word(logic [AW:0] a);
        return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11};
    endfunction

    assign array_data = arr_word(array_addr);

    flash_bus_front #(.AW(AW), .DQ_W(DQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .word_mode(word_mode), .addr(addr), .dq(dq), .rd_src(rd_src),
        .array_data(array_data), .id_code(id_code), .prot_code(prot_code),
        .stat_flags(stat_flags), .array_addr(array_addr), .wr_pulse(wr_pulse),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_pulse === 1'b1) begin
            pulse_cnt++;
            cap_addr = wr_addr;
            cap_data = wr_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tb_en = '0;
        #5;
    endtask

    task automatic settle_pulse();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; word_mode = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tb_en = '0; rd_src = 2'd0; addr = 8'h10;
        #23;
        check("R11 bus floats in reset", dq, 16'hzzzz);
        we_n = 1'b0; #5; we_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 no pulse in reset", pulse_cnt, 0);
        ce_n = 1'b1; oe_n = 1'b1; #5;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_we_write();
        word_mode = 1'b1; pulse_cnt = 0;
        addr = 8'h11; ce_n = 1'b0; #7;
        addr = 8'h22; #5;
        we_n = 1'b0; #5;
        addr = 8'h33; tb_en = 16'hFFFF; tb_val = 16'hBEEF; #10;
        we_n = 1'b1; #5;
        tb_val = 16'h1234; ce_n = 1'b1; #5;
        idle_bus();
        settle_pulse();
        check("R10 single pulse (WE write)", pulse_cnt, 1);
        check("R1 address at later fall", cap_addr, {1'b0, 8'h22});
        check("R2 R3 word data at first rise", cap_data, 16'hBEEF);
    endtask

    task automatic t_ce_write();
        word_mode = 1'b1; pulse_cnt = 0;
        addr = 8'h44; we_n = 1'b0; #6;
        addr = 8'h55; #3;
        ce_n = 1'b0; #3;
        addr = 8'h66; tb_en = 16'hFFFF; tb_val = 16'hCAFE; #10;
        ce_n = 1'b1; #4;
        tb_val = 16'h0BAD; #4;
        we_n = 1'b1; #4;
        idle_bus();
        settle_pulse();
        check("R10 single pulse (CE write)", pulse_cnt, 1);
        check("R1 address at CE fall", cap_addr, {1'b0, 8'h55});
        check("R2 data at CE rise", cap_data, 16'hCAFE);
    endtask

    task automatic t_byte_write();
        word_mode = 1'b0; pulse_cnt = 0;
        addr = 8'h9A; tb_en = 16'hFFFF; tb_val = 16'hFF5A; #4;
        ce_n = 1'b0; we_n = 1'b0; #10;
        we_n = 1'b1; #5;
        ce_n = 1'b1; #4;
        idle_bus();
        settle_pulse();
        check("R10 single pulse (byte write)", pulse_cnt, 1);
        check("R4 byte write address", cap_addr, {8'h9A, 1'b1});
        check("R4 byte write upper ignored", cap_data, 16'h005A);
    endtask

    task automatic t_word_read();
        word_mode = 1'b1; tb_en = '0; rd_src = 2'd0; addr = 8'h42; #3;
        ce_n = 1'b0; oe_n = 1'b0; #5;
        check("R3 word array read", dq, arr_word({1'b0, 8'h42}));
        oe_n = 1'b1; #3;
        check("R6 float when oe_n high", dq, 16'hzzzz);
        oe_n = 1'b0; #3;
        ce_n = 1'b1; #3;
        check("R6 float when ce_n high", dq, 16'hzzzz);
        idle_bus();
    endtask

    task automatic t_byte_read();
        logic [DQ_W-1:0] w;
        word_mode = 1'b0; rd_src = 2'd0; addr = 8'h21;
        tb_en = 16'h8000; tb_val = 16'h0000; #3;
        ce_n = 1'b0; oe_n = 1'b0; #5;
        w = arr_word({8'h21, 1'b0});
        check("R5 byte read lower", dq[7:0], w[7:0]);
        check("R4 middle pins float", dq[14:8], 7'bzzzzzzz);
        tb_val = 16'h8000; #4;
        w = arr_word({8'h21, 1'b1});
        check("R5 byte read upper", dq[7:0], w[15:8]);
        idle_bus();
    endtask

    task automatic read_once(input logic [1:0] src, output logic [DQ_W-1:0] v);
        rd_src = src; #2;
        ce_n = 1'b0; oe_n = 1'b0; #5;
        v = dq;
        oe_n = 1'b1; ce_n = 1'b1; #4;
    endtask

    task automatic t_sources();
        logic [DQ_W-1:0] v;
        word_mode = 1'b1; tb_en = '0;
        id_code = 8'h20; prot_code = 8'h01; stat_flags = 5'b10110;
        read_once(2'd1, v); check("R7 ident source", v, 16'h0020);
        read_once(2'd2, v); check("R7 protect source", v, 16'h0001);
        read_once(2'd3, v); check("R8 status layout A", v, 16'h00A8);
        stat_flags = 5'b01001;
        read_once(2'd3, v); check("R8 status layout B", v, 16'h0044);
        word_mode = 1'b0; tb_en = 16'h8000; tb_val = 16'h8000; stat_flags = 5'b10110;
        read_once(2'd3, v); check("R7 byte mode status low lane", v[7:0], 8'hA8);
        idle_bus();
    endtask

    task automatic t_src_hold();
        word_mode = 1'b1; tb_en = '0; addr = 8'h07; id_code = 8'h20;
        rd_src = 2'd1; #2;
        ce_n = 1'b0; oe_n = 1'b0; #5;
        check("R9 ident at open", dq, 16'h0020);
        rd_src = 2'd0; #4;
        check("R9 select change ignored mid-read", dq, 16'h0020);
        oe_n = 1'b1; #3; oe_n = 1'b0; #5;
        check("R9 new select on next read", dq, arr_word({1'b0, 8'h07}));
        rst_n = 1'b0; #4;
        check("R6 R11 float on reset mid-read", dq, 16'hzzzz);
        idle_bus();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_we_write();
        t_ce_write();
        t_byte_write();
        t_word_read();
        t_byte_read();
        t_sources();
        t_src_hold();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule